// File: doc/BRIEF.md
# Pipeline Stage Bit Alignment Skew Buffer

A chain of twenty single-bit conversion stages resolves one decision bit per stage for each input sample. Consecutive stages work on opposite halves of the clock, so the bits that belong to one sample leave the stages spread across twenty consecutive half cycles. This block takes the raw stage bits as they appear and delays each one so that all twenty bits of a sample come out together as one word, with a strobe marking each new word.

The two clock halves are modelled as two non-overlapping enables on one system clock. Each enable pulse is one half-cycle "tick". Every delay element is a register that loads only on the tick of its own half. Each stage's lane starts on that stage's own half and alternates along its length. The earliest stage gets the longest lane and the final stage gets none, which gives a triangular skew. The output word register loads on the final stage's half. Gap cycles with neither enable high are allowed anywhere and simply stretch time.

Top module: `stage_bit_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, `word_o` and `valid_o` are cleared to zero and the fill count restarts.
- R2: Stage k (k = 1..20) drives input bit `stage_bits_i[20-k]` and appears at output bit `word_o[20-k]`. Bit 19 is stage 1, the most significant, and bit 0 is stage 20.
- R3: Odd stages are sampled only on `ph1_en` ticks and even stages only on `ph2_en` ticks. A stage's input value during a tick of the other half, or during a cycle with no enable, has no effect on any output word. The two enables are never high together.
- R4: A bit that stage k presents on its own tick passes through 20-k half-tick delay elements. Stage 20's bit is loaded into the output word directly, on the same tick on which it is presented.
- R5: Take a sample whose stage 1 bit is presented on tick t, counting enable ticks only. Stage k of that sample is presented on tick t+k-1, and the whole sample appears on `word_o` after the edge of tick t+19. `word_o` changes only on `ph2_en` edges and holds through `ph1_en` ticks and idle cycles.
- R6: `valid_o` is high for exactly the one clock cycle that follows each `ph2_en` word update once the pipeline has filled, and is low at all other times.
- R7: Fill ticks are counted from the first `ph1_en` tick after reset, and any `ph2_en` tick before it is ignored. The first `valid_o` follows the 20th counted tick, which is tick index 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ph1_en | input | 1 | Tick enable for the half on which odd stages resolve |
| ph2_en | input | 1 | Tick enable for the half on which even stages resolve |
| stage_bits_i | input | 20 | Raw stage decision bits; bit 20-k is stage k |
| word_o | output | 20 | Aligned sample word; bit 19 is stage 1 |
| valid_o | output | 1 | One-cycle strobe after each aligned word update |

## Verification
Directed words are pushed through the pipeline first: all ones, all zeros, both alternating patterns, and a one-hot bit at each end. These expose swapped lanes, bit-order mistakes and lanes that are stuck. Random sample words follow, and during the ticks of the other half and during gaps every stage input carries random junk. A lane that loads on the wrong half, or a lane with one element too many or too few, therefore produces a wrong word instead of an accidentally correct one. Idle gap cycles are inserted at random to separate a count of clock cycles from a count of enable ticks. One stream starts with a stray `ph2_en` tick, which shows whether filling waits for the first `ph1_en` tick and whether the first strobe falls exactly on tick 19.

// File: rtl/stage_align_pkg.sv
package stage_align_pkg;

    localparam int unsigned N_STAGES_DEF = 20;

    // Which half of the clock a storage element loads on.
    typedef enum logic {
        PH_A = 1'b0,   // odd stages resolve here
        PH_B = 1'b1    // even stages resolve here
    } phase_e;

    // Element idx of the lane for output bit bitpos (stage n-bitpos).
    // The first element runs on the stage's own half; later ones alternate.
    function automatic phase_e cell_phase(int unsigned n, int unsigned bitpos,
                                          int unsigned idx);
        return (((n - 1 - bitpos + idx) % 2) == 0) ? PH_A : PH_B;
    endfunction

    // The output word loads on the half of the final stage.
    function automatic phase_e word_phase(int unsigned n);
        return (((n - 1) % 2) == 0) ? PH_A : PH_B;
    endfunction

    function automatic logic pick_en(phase_e p, logic en_a, logic en_b);
        return (p == PH_A) ? en_a : en_b;
    endfunction

endpackage

// File: rtl/half_cell.sv
module half_cell (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic d,
    output logic q
);
    // One half-tick storage element: loads on its own half, holds otherwise.
    always_ff @(posedge clk) begin
        if (rst)     q <= 1'b0;
        else if (en) q <= d;
    end
endmodule

// File: rtl/skew_lane.sv
module skew_lane
    import stage_align_pkg::*;
#(
    parameter int unsigned N_STAGES = N_STAGES_DEF,
    parameter int unsigned BITPOS   = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic ph1_en,
    input  logic ph2_en,
    input  logic d,
    output logic q
);
    // Lane depth equals the bit position: bit 0 (last stage) has no element.
    localparam int unsigned DEPTH = BITPOS;

    logic [DEPTH:0] tap;
    assign tap[0] = d;

    for (genvar j = 0; j < DEPTH; j++) begin : g_cell
        localparam phase_e CPH = cell_phase(N_STAGES, BITPOS, j);
        logic cell_en;
        assign cell_en = pick_en(CPH, ph1_en, ph2_en);
        half_cell u_cell (
            .clk (clk),
            .rst (rst),
            .en  (cell_en),
            .d   (tap[j]),
            .q   (tap[j+1])
        );
    end

    assign q = tap[DEPTH];
endmodule

// File: rtl/fill_tracker.sv
module fill_tracker
    import stage_align_pkg::*;
#(
    parameter int unsigned N_STAGES = N_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic ph1_en,
    input  logic ph2_en,
    output logic filled
);
    localparam int unsigned CNT_W = $clog2(N_STAGES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_STAGES - 1);

    logic [CNT_W-1:0] seen;
    logic             first_en;
    logic             step;

    // Counting begins on the half of stage 1; after that every tick counts.
    assign first_en = pick_en(PH_A, ph1_en, ph2_en);
    assign step     = (seen == '0) ? first_en : (ph1_en | ph2_en);

    always_ff @(posedge clk) begin
        if (rst)                        seen <= '0;
        else if (step && seen != LAST)  seen <= seen + 1'b1;
    end

    assign filled = (seen == LAST);
endmodule

// File: rtl/stage_bit_aligner.sv
module stage_bit_aligner
    import stage_align_pkg::*;
#(
    parameter int unsigned N_STAGES = N_STAGES_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ph1_en,
    input  logic                ph2_en,
    input  logic [N_STAGES-1:0] stage_bits_i,
    output logic [N_STAGES-1:0] word_o,
    output logic                valid_o
);
    localparam phase_e OUT_PH = word_phase(N_STAGES);

    logic [N_STAGES-1:0] lane_q;
    logic                filled;
    logic                out_en;

    assign out_en = pick_en(OUT_PH, ph1_en, ph2_en);

    for (genvar b = 0; b < N_STAGES; b++) begin : g_lane
        skew_lane #(
            .N_STAGES (N_STAGES),
            .BITPOS   (b)
        ) u_lane (
            .clk    (clk),
            .rst    (rst),
            .ph1_en (ph1_en),
            .ph2_en (ph2_en),
            .d      (stage_bits_i[b]),
            .q      (lane_q[b])
        );
    end

    fill_tracker #(
        .N_STAGES (N_STAGES)
    ) u_fill (
        .clk    (clk),
        .rst    (rst),
        .ph1_en (ph1_en),
        .ph2_en (ph2_en),
        .filled (filled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= out_en & filled;
            if (out_en) word_o <= lane_q;
        end
    end
endmodule

// File: rtl/stage_bit_aligner_chk.sv
module stage_bit_aligner_chk
    import stage_align_pkg::*;
#(
    parameter int unsigned N_STAGES = N_STAGES_DEF
) (
    input logic                clk,
    input logic                rst,
    input logic                ph1_en,
    input logic                ph2_en,
    input logic [N_STAGES-1:0] stage_bits_i,
    input logic [N_STAGES-1:0] word_o,
    input logic                valid_o
);
    localparam phase_e OUT_PH = word_phase(N_STAGES);
    localparam int unsigned SW = $clog2(N_STAGES + 1);
    localparam logic [SW-1:0] FULL = SW'(N_STAGES);

    logic          out_en;
    logic [SW-1:0] ticks_chk;

    assign out_en = pick_en(OUT_PH, ph1_en, ph2_en);

    // Independent tick count, saturating at N_STAGES (the tick that fills).
    always_ff @(posedge clk) begin
        if (rst)
            ticks_chk <= '0;
        else if (ticks_chk != FULL &&
                 ((ticks_chk == '0) ? ph1_en : (ph1_en | ph2_en)))
            ticks_chk <= ticks_chk + 1'b1;
    end

    // R3: the two half enables never overlap
    p_phase_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(ph1_en && ph2_en));

    // R6: a strobe only ever follows an output-half tick
    p_valid_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(out_en));

    // R5: the word holds when the previous cycle had no output-half tick
    p_word_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(out_en)) |-> $stable(word_o));

    // R4: the final stage reaches the word with no added delay
    p_last_stage_direct_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(out_en)) |-> (word_o[0] == $past(stage_bits_i[0])));

    // R7: no strobe before the pipeline has seen all filling ticks
    p_no_early_valid_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (ticks_chk == FULL));
endmodule

bind stage_bit_aligner stage_bit_aligner_chk #(
    .N_STAGES (N_STAGES)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ph1_en       (ph1_en),
    .ph2_en       (ph2_en),
    .stage_bits_i (stage_bits_i),
    .word_o       (word_o),
    .valid_o      (valid_o)
);

// File: tb/stage_bit_aligner_bench.sv
module stage_bit_aligner_bench;
    localparam int N  = 20;
    localparam int MS = 160;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ph1_en = 1'b0;
    logic          ph2_en = 1'b0;
    logic [N-1:0]  stage_bits_i = '0;
    logic [N-1:0]  word_o;
    logic          valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    int n_cycles = 0;

    logic [N-1:0] samp [0:MS-1];

    always #4 clk = ~clk;   // 125 MHz

    stage_bit_aligner u_stage_bit_aligner (
        .clk          (clk),
        .rst          (rst),
        .ph1_en       (ph1_en),
        .ph2_en       (ph2_en),
        .stage_bits_i (stage_bits_i),
        .word_o       (word_o),
        .valid_o      (valid_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    // One clock: drive away from the edge, sample 1 ns after the edge.
    task automatic do_cycle(input bit p1, input bit p2, input logic [N-1:0] bits);
        @(negedge clk);
        ph1_en       = p1;
        ph2_en       = p2;
        stage_bits_i = bits;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [N-1:0] junk();
        return N'($urandom);
    endfunction

    // Stage k presents sample n on tick 2n+k-1; other stages carry junk.
    function automatic logic [N-1:0] build_bits(int t);
        logic [N-1:0] v = junk();
        for (int k = 1; k <= N; k++) begin
            if (((k - 1) % 2) == (t % 2) && t >= k - 1)
                v[N-k] = samp[(t - k + 1) / 2][N-k];
        end
        return v;
    endfunction

    task automatic load_samples();
        samp[0] = '1;
        samp[1] = '0;
        samp[2] = N'(20'hAAAAA);
        samp[3] = N'(20'h55555);
        samp[4] = N'(1) << (N - 1);
        samp[5] = N'(1);
        for (int i = 6; i < MS; i++) samp[i] = junk();
    endtask

    task automatic run_stream(input int ns, input bit lead_ph2, input int gap_pct);
        logic [N-1:0] prev;
        rst = 1'b1;
        for (int i = 0; i < 3; i++) do_cycle(1'b0, 1'b0, junk());
        // R1: reset clears the word and the strobe
        check(word_o == '0, "R1 word after reset", word_o, '0);
        check(valid_o == 1'b0, "R1 valid after reset", N'(valid_o), '0);
        rst = 1'b0;
        if (lead_ph2) begin
            do_cycle(1'b0, 1'b1, junk());
            // R7: a stray ph2 tick before the first ph1 tick is not counted
            check(valid_o == 1'b0, "R7 stray ph2 no strobe", N'(valid_o), '0);
        end
        for (int t = 0; t < 2 * ns + 19; t++) begin
            if (int'($urandom % 100) < gap_pct) begin
                prev = word_o;
                do_cycle(1'b0, 1'b0, junk());
                // R3/R5: idle cycle inputs ignored, word held, no strobe
                check(word_o == prev, "R3 idle word held", word_o, prev);
                check(valid_o == 1'b0, "R6 idle no strobe", N'(valid_o), '0);
            end
            prev = word_o;
            do_cycle((t % 2) == 0, (t % 2) == 1, build_bits(t));
            if ((t % 2) == 0) begin
                check(word_o == prev, "R5 word held on ph1", word_o, prev);
                check(valid_o == 1'b0, "R6 no strobe on ph1", N'(valid_o), '0);
            end else if (t < 19) begin
                check(valid_o == 1'b0, "R7 no strobe before fill", N'(valid_o), '0);
            end else begin
                check(valid_o == 1'b1, "R6 strobe after ph2 update", N'(valid_o), N'(1));
                // R2/R4/R5: aligned word for sample (t-19)/2
                check(word_o == samp[(t - 19) / 2], "R4 aligned word",
                      word_o, samp[(t - 19) / 2]);
            end
        end
        prev = word_o;
        do_cycle(1'b0, 1'b0, junk());
        check(valid_o == 1'b0, "R6 strobe lasts one cycle", N'(valid_o), '0);
        check(word_o == prev, "R5 final word held", word_o, prev);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            n_cycles++;
            if (n_cycles > 200000) begin
                n_fail++;
                $display("FAIL watchdog expired after %0d cycles", n_cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd20417));
        load_samples();
        run_stream(40, 1'b0, 0);    // directed words, no gaps
        load_samples();
        run_stream(70, 1'b1, 30);   // stray ph2 first, random gaps
        load_samples();
        run_stream(30, 1'b0, 60);   // heavy gaps after a mid-run reset
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule